// File: doc/BRIEF.md
# Signed Reactance Emulation Filter

This block is a per-sample fixed-point filter placed between a voltage digitizer and a current-output converter that share one clock. Each accepted voltage sample produces one current-command sample, chosen so that the terminals behave like a capacitance or an inductance. The sign of that element follows the sign of the coefficient, so negative elements are handled the same way as positive ones. The output register holds its value between updates, which is the zero-order hold the converter expects. Correct emulation needs input content below half the sample rate. Sample rate and coefficient scale together: halving the period and doubling the coefficient gives the same capacitance.

A small state machine records the element form used by the previous accepted sample. The states are `ST_CAP` (capacitor, backward difference), `ST_ACC` (inductor, running sum), `ST_BIL` (inductor, trapezoidal/bilinear sum) and `ST_IDLE` (output forced to zero). Each accepted sample moves the machine to the state that its `mode` input selects. This happens from any state and to any state, staying put when the mode does not change. A transition to a different state means the sample that causes it runs with zeroed history. Reset puts the machine in `ST_CAP`. A clear cycle leaves the state where it is.

Top module: `imm_emul_core`

## Requirements
- R1: After reset `iout` is 0 and `out_valid` is 0.
- R2: With `mode`=0 (capacitor), an accepted sample gives iout = round((K·(v − vprev)) / 2^14), where K is `coef` as a signed Q2.14 value and rounding adds 2^13 and then floors.
- R3: With `mode`=1 (running-sum inductor), iout = iprev + round((K·v) / 2^14). Rounding adds 2^13 and then floors.
- R4: With `mode`=2 (bilinear inductor), iout = iprev + round((K·(v + vprev)) / 2^15). Rounding adds 2^14 and then floors.
- R5: K may have either sign. A negated K gives the negated increment, with no clamping of the coefficient.
- R6: Every result saturates to the range −32768..32767. The stored iprev is the saturated value, so the running sum never wraps.
- R7: An accepted sample (`in_valid`=1, `clear`=0) raises `out_valid` and updates `iout` in the next cycle, and in no other cycle.
- R8: In a cycle with `in_valid`=0, `iout`, vprev and iprev stay unchanged and `out_valid` is 0.
- R9: When the mode of an accepted sample differs from the mode of the previous accepted sample, that sample is computed with vprev = 0 and iprev = 0.
- R10: `clear`=1 takes priority over `in_valid`. It sets vprev, iprev and `iout` to 0 and drives `out_valid` to 0 in the next cycle.
- R11: With `mode`=3, an accepted sample gives `iout` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous history clear |
| in_valid | input | 1 | Qualifies `vin`, `mode` and `coef` |
| mode | input | 2 | 0 capacitor, 1 running-sum inductor, 2 bilinear inductor, 3 idle |
| coef | input | 16 | Signed Q2.14 element coefficient K |
| vin | input | 16 | Signed voltage sample |
| out_valid | output | 1 | New current sample present |
| iout | output | 16 | Signed current command, held between updates |

## Verification
The assertions assume that `mode` and `coef` are sampled only when `in_valid` is high. They also assume that `clear` may arrive in any cycle, including a cycle with `in_valid` high. The stimulus drives every input half a period away from the sampling edge. It sweeps the full signed ranges of `coef` and `vin`, switches mode only occasionally, and mixes in idle cycles and clears. This gives both long stretches of history and many history resets.

// File: rtl/imm_pkg.sv
package imm_pkg;
    // Element form; the encoding equals the mode input value.
    typedef enum logic [1:0] {
        ST_CAP  = 2'd0,
        ST_ACC  = 2'd1,
        ST_BIL  = 2'd2,
        ST_IDLE = 2'd3
    } mode_st_t;
endpackage

// File: rtl/imm_mode_fsm.sv
module imm_mode_fsm
    import imm_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           take,
    input  logic [1:0]     mode_in,
    output mode_st_t       cur_st,
    output mode_st_t       req_st,
    output logic           use_hist
);
    mode_st_t state_q;

    // Output process: decode requested form, decide whether history applies.
    always_comb begin
        unique case (mode_in)
            2'd0:    req_st = ST_CAP;
            2'd1:    req_st = ST_ACC;
            2'd2:    req_st = ST_BIL;
            default: req_st = ST_IDLE;
        endcase
        use_hist = (req_st == state_q);
        cur_st   = state_q;
    end

    // State register: moves to the requested form on each accepted sample.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_CAP;
        else if (take)
            state_q <= req_st;
    end

    // R9: an accepted sample always leaves the machine in the requested form
    a_r9_state_follows: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (state_q == $past(req_st)));
endmodule

// File: rtl/imm_datapath.sv
module imm_datapath
    import imm_pkg::*;
#(
    parameter int DW    = 16,
    parameter int CW    = 16,
    parameter int CFRAC = 14
) (
    input  mode_st_t              form,
    input  logic                  use_hist,
    input  logic signed [DW-1:0]  vin,
    input  logic signed [DW-1:0]  vprev,
    input  logic signed [DW-1:0]  iprev,
    input  logic signed [CW-1:0]  coef,
    output logic signed [DW-1:0]  inext
);
    localparam int AW = DW + CW + 2;
    localparam logic signed [AW-1:0] RND_1 = AW'(1) <<< (CFRAC - 1);
    localparam logic signed [AW-1:0] RND_2 = AW'(1) <<< CFRAC;
    localparam logic signed [AW-1:0] MAXV  = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [AW-1:0] MINV  = {{(AW-DW+1){1'b1}}, {(DW-1){1'b0}}};
    localparam logic signed [DW-1:0] MAXD  = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [DW-1:0] MIND  = {1'b1, {(DW-1){1'b0}}};

    logic signed [AW-1:0] vx, vhx, ihx, cx, acc;

    always_comb begin
        vx  = AW'(vin);
        cx  = AW'(coef);
        vhx = use_hist ? AW'(vprev) : '0;
        ihx = use_hist ? AW'(iprev) : '0;
        unique case (form)
            ST_CAP:  acc = (cx * (vx - vhx) + RND_1) >>> CFRAC;
            ST_ACC:  acc = ihx + ((cx * vx + RND_1) >>> CFRAC);
            ST_BIL:  acc = ihx + ((cx * (vx + vhx) + RND_2) >>> (CFRAC + 1));
            default: acc = '0;
        endcase
        if (acc > MAXV)
            inext = MAXD;
        else if (acc < MINV)
            inext = MIND;
        else
            inext = acc[DW-1:0];
    end

    // R11: idle form never produces a nonzero command
    always_comb begin
        if (form == ST_IDLE)
            a_r11_idle_comb: assert (inext == '0);
    end
endmodule

// File: rtl/imm_emul_core.sv
module imm_emul_core
    import imm_pkg::*;
#(
    parameter int DW    = 16,
    parameter int CW    = 16,
    parameter int CFRAC = 14
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  in_valid,
    input  logic [1:0]            mode,
    input  logic signed [CW-1:0]  coef,
    input  logic signed [DW-1:0]  vin,
    output logic                  out_valid,
    output logic signed [DW-1:0]  iout
);
    logic                  take;
    logic                  use_hist;
    mode_st_t              cur_st, req_st;
    logic signed [DW-1:0]  vprev_q, iout_q, inext;
    logic                  ovld_q;

    assign take = in_valid && !clear;

    imm_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .mode_in  (mode),
        .cur_st   (cur_st),
        .req_st   (req_st),
        .use_hist (use_hist)
    );

    imm_datapath #(.DW(DW), .CW(CW), .CFRAC(CFRAC)) u_dp (
        .form     (req_st),
        .use_hist (use_hist),
        .vin      (vin),
        .vprev    (vprev_q),
        .iprev    (iout_q),
        .coef     (coef),
        .inext    (inext)
    );

    // History and zero-order-hold output registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vprev_q <= '0;
            iout_q  <= '0;
            ovld_q  <= 1'b0;
        end else if (clear) begin
            vprev_q <= '0;
            iout_q  <= '0;
            ovld_q  <= 1'b0;
        end else if (in_valid) begin
            vprev_q <= vin;
            iout_q  <= inext;
            ovld_q  <= 1'b1;
        end else begin
            ovld_q  <= 1'b0;
        end
    end

    assign out_valid = ovld_q;
    assign iout      = iout_q;

    a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> out_valid);
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !clear) |=> ($stable(iout) && $stable(vprev_q) && !out_valid));
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (iout == '0 && vprev_q == '0 && !out_valid));
    a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (take && mode == 2'd3) |=> (iout == '0));
    a_r2_flat_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (take && mode == 2'd0 && cur_st == ST_CAP && vin == vprev_q) |=> (iout == '0));
endmodule

// File: tb/tb_imm_emul_core.sv
module tb_imm_emul_core;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clear = 1'b0;
    logic in_valid = 1'b0;
    logic [1:0] mode = 2'd0;
    logic signed [15:0] coef = '0;
    logic signed [15:0] vin = '0;
    logic out_valid;
    logic signed [15:0] iout;

    int n_chk = 0;
    int n_fail = 0;
    int mv = 0, mi = 0, mm = 0;
    bit done = 0;

    always #4 clk = ~clk;

    imm_emul_core dut (
        .clk(clk), .rst_n(rst_n), .clear(clear), .in_valid(in_valid),
        .mode(mode), .coef(coef), .vin(vin),
        .out_valid(out_valid), .iout(iout)
    );

    function automatic longint rnd(longint x, int s);
        return (x + (longint'(1) <<< (s - 1))) >>> s;
    endfunction

    function automatic int sat(longint x);
        if (x > 32767) return 32767;
        if (x < -32768) return -32768;
        return int'(x);
    endfunction

    function automatic int model(int md, int k, int v, int vp, int ip);
        case (md)
            0: return sat(rnd(longint'(k) * (v - vp), 14));
            1: return sat(ip + rnd(longint'(k) * v, 14));
            2: return sat(ip + rnd(longint'(k) * (v + vp), 15));
            default: return 0;
        endcase
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive at a falling edge, check at the next falling edge.
    task automatic step(bit vld, bit clr, int md, int k, int v, string req);
        int e_i;
        bit e_v;
        in_valid = vld; clear = clr; mode = md[1:0];
        coef = k[15:0]; vin = v[15:0];
        if (clr) begin
            mv = 0; mi = 0; e_i = 0; e_v = 0;
        end else if (vld) begin
            if (md != mm) begin mv = 0; mi = 0; end
            e_i = model(md, k, v, mv, mi);
            mv = v; mi = e_i; mm = md; e_v = 1;
        end else begin
            e_i = mi; e_v = 0;
        end
        @(negedge clk);
        chk({req, " out_valid"}, int'(out_valid), int'(e_v));
        chk({req, " iout"}, int'(iout), e_i);
    endtask

    initial begin
        int cnt = 0;
        while (!done) begin
            @(posedge clk);
            cnt++;
            if (cnt > 150000) begin
                n_fail++; n_chk++;
                $display("FAIL watchdog expired");
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk("R1 iout", int'(iout), 0);
        chk("R1 out_valid", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", int'(iout), 0);

        // R2 capacitor, K=0.5
        step(1, 0, 0, 8192, 0, "R2");
        step(1, 0, 0, 8192, 1000, "R2");
        chk("R2 literal", int'(iout), 500);
        step(1, 0, 0, 8192, 1000, "R2");
        chk("R2 flat", int'(iout), 0);
        // R5 negative K
        step(1, 0, 0, -8192, 0, "R5");
        chk("R5 literal", int'(iout), 500);
        step(1, 0, 0, 82, 10000, "R2 small K");
        chk("R2 small K literal", int'(iout), 50);

        // R9 + R3 accumulator, K=1.0
        step(1, 0, 1, 16384, 100, "R3");
        chk("R9 first acc", int'(iout), 100);
        step(1, 0, 1, 16384, 100, "R3");
        step(1, 0, 1, 16384, 100, "R3");
        chk("R3 literal", int'(iout), 300);
        // R8 hold
        step(0, 0, 1, 16384, 9999, "R8");
        chk("R8 held", int'(iout), 300);
        step(1, 0, 1, -16384, 50, "R5 acc");
        chk("R5 acc literal", int'(iout), 250);
        // R9 switch to capacitor uses zero history
        step(1, 0, 0, 16384, 300, "R9");
        chk("R9 literal", int'(iout), 300);

        // R4 bilinear
        step(1, 0, 2, 16384, 100, "R4");
        chk("R4 first", int'(iout), 50);
        step(1, 0, 2, 16384, 100, "R4");
        chk("R4 second", int'(iout), 150);

        // R6 saturation
        step(1, 0, 1, 32767, 32767, "R6");
        step(1, 0, 1, 32767, 32767, "R6");
        chk("R6 high", int'(iout), 32767);
        step(1, 0, 1, 32767, 32767, "R6");
        step(1, 0, 1, 32767, -32768, "R6");
        step(1, 0, 1, 32767, -32768, "R6");
        step(1, 0, 1, 32767, -32768, "R6");
        chk("R6 low", int'(iout), -32768);
        step(1, 0, 0, -32768, 32767, "R6 cap");
        chk("R6 cap low", int'(iout), -32768);

        // R10 clear with in_valid high
        step(1, 1, 0, 16384, 1234, "R10");
        step(1, 0, 0, 16384, 40, "R10 after");
        chk("R10 zero vprev", int'(iout), 40);

        // R11 idle mode
        step(1, 0, 3, 16384, 5000, "R11");
        chk("R11 literal", int'(iout), 0);

        // R7 back-to-back and gaps, random mix with sinusoid
        for (int n = 0; n < 600; n++) begin
            int md, k, v;
            bit vld, clr;
            md = (n % 40 < 20) ? mm : int'($urandom % 4);
            if (md == 3 && ($urandom % 4) != 0) md = 1;
            k = int'($signed($urandom % 65536 - 32768));
            if (n % 3 == 0) k = k / 64;
            if (n % 2 == 0) v = $rtoi(14000.0 * $sin(0.21 * n));
            else v = int'($urandom % 65536) - 32768;
            vld = ($urandom % 4) != 0;
            clr = ($urandom % 50) == 0;
            step(vld, clr, md, k, v, "R7 random");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule